// File: doc/BRIEF.md
# Segment Translator With Privilege Check

This block turns a segmented virtual address into a linear address. A request carries a 14-bit selector and a 32-bit displacement. It also carries the access kind, the current privilege of the requester and a bit that turns segmentation on or off. With segmentation on, the selector picks one descriptor from either a global or a local table. The descriptor's base is added to the displacement. The same descriptor's residency bit, privilege level, attribute flags and limit decide whether the access is allowed.

The result comes back one clock after the request. It is either a linear address with the fault flag clear, or a fault flag with a cause code. The cause codes follow a fixed priority. A write port fills the two descriptor tables one entry per clock. Loading descriptors from memory and any later paging step are left to neighbouring logic.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is held, `rsp_valid`, `fault`, `fault_cause` and `lin_addr` are all zero. Reset clears every descriptor of both tables to non-resident.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. The response fields describe the request of the previous cycle.
- R3: With `seg_en` low, a request returns `lin_addr` equal to `disp` with `fault` low and `fault_cause` 0, whatever the selector, access kind, privilege and table contents.
- R4: Selector layout: bits [1:0] are the requested privilege, bit [2] picks the table (0 global, 1 local), and bits [13:3] are the entry index. An index of 16 or more (past the table depth) gives cause 1.
- R5: An allowed access returns `lin_addr` = descriptor base + `disp`, modulo 2^32.
- R6: A descriptor whose resident bit is 0 gives cause 1 (not present).
- R7: Privilege values run from 0 (most protected) to 3 (least protected). If `cpl` or the requested privilege is numerically greater than the descriptor privilege, the result is cause 2.
- R8: Access encoding is 0 read, 1 write, 2 execute, 3 reserved. On a data segment (code flag 0), read is always allowed, write is allowed only with the attribute flag 1, and execute is refused. On a code segment, read is always allowed, execute is allowed only with the attribute flag 1 (read-execute), and write is refused. Reserved is always refused. A refusal gives cause 3.
- R9: A `disp` above the descriptor limit gives cause 4. A `disp` equal to the limit is inside the segment.
- R10: When several checks fail, the reported cause is the first in this order: not present (1), privilege (2), access (3), bounds (4).
- R11: A faulting response has `fault` high, a nonzero cause and `lin_addr` zero. A clean response has `fault` low and cause 0.
- R12: A write with `wr_en` high stores base, limit, privilege, resident, code and attribute fields into the entry chosen by `wr_local` and `wr_idx` at the clock edge. A lookup in the same cycle as the write sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| seg_en | input | 1 | 1: translate through descriptors, 0: pass displacement through |
| sel | input | 14 | Selector: index, table bit, requested privilege |
| disp | input | 32 | Displacement within the segment |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cpl | input | 2 | Current privilege of the requester |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target table: 0 global, 1 local |
| wr_idx | input | 4 | Write target entry |
| wr_base | input | 32 | Segment base to store |
| wr_limit | input | 32 | Highest valid displacement to store |
| wr_dpl | input | 2 | Descriptor privilege to store |
| wr_present | input | 1 | Resident flag to store |
| wr_code | input | 1 | 1: code segment, 0: data segment |
| wr_perm | input | 1 | Attribute flag (write allowed on data, execute allowed on code) |
| rsp_valid | output | 1 | Response for last cycle's request |
| lin_addr | output | 32 | Linear address, zero on a fault |
| fault | output | 1 | Request refused |
| fault_cause | output | 3 | 0 none, 1 not present, 2 privilege, 3 access, 4 bounds |

## Verification
The embedded properties assume that inputs are stable and known when a clock edge arrives. They also assume `req_valid` is low during reset, so no request from reset time leaks into the first response. The bench drives every input on the falling edge and holds `req_valid` low through reset. It drives each request for exactly one cycle and samples the registered result one falling edge later. A sweep covers both tables, every entry plus two indices past the end, every access kind, every pair of current and requested privilege, and displacements at zero, at the limit and one past it. This sweep visits each cause and each overlap of causes under the priority rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int ADDR_W = 32;
    localparam int PRIV_W = 2;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_PRIV   = 3'd2,
        CAUSE_ACCESS = 3'd3,
        CAUSE_BOUNDS = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [PRIV_W-1:0] dpl;
        logic              present;
        logic              is_code;
        logic              perm;
    } desc_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    desc_t ent_d [DEPTH];
    desc_t ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_desc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rd_desc = ent_q[rd_idx];

    // R12
    entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_desc)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !ent_q[0].present);

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  desc_t             desc,
    input  logic              in_range,
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] rpl,
    input  logic [1:0]        acc,
    input  logic [ADDR_W-1:0] disp,
    output cause_e            cause
);

    logic absent;
    logic priv_bad;
    logic acc_ok;
    logic over_limit;

    always_comb begin
        absent     = !in_range || !desc.present;
        priv_bad   = (cpl > desc.dpl) || (rpl > desc.dpl);
        over_limit = disp > desc.limit;
        case (acc)
            ACC_READ:  acc_ok = 1'b1;
            ACC_WRITE: acc_ok = !desc.is_code && desc.perm;
            ACC_EXEC:  acc_ok = desc.is_code && desc.perm;
            default:   acc_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (absent) begin
            cause = CAUSE_ABSENT;
        end else if (priv_bad) begin
            cause = CAUSE_PRIV;
        end else if (!acc_ok) begin
            cause = CAUSE_ACCESS;
        end else if (over_limit) begin
            cause = CAUSE_BOUNDS;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    // R8
    always_comb begin
        if (in_range && desc.present && (cause == CAUSE_NONE)) begin
            code_write_chk: assert (!(desc.is_code && (acc == ACC_WRITE)));
        end
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int SEL_W = 14,
    parameter int DEPTH = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int FIELD_W = SEL_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              seg_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [31:0]       disp,
    input  logic [1:0]        acc,
    input  logic [1:0]        cpl,
    input  logic              wr_en,
    input  logic              wr_local,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_base,
    input  logic [31:0]       wr_limit,
    input  logic [1:0]        wr_dpl,
    input  logic              wr_present,
    input  logic              wr_code,
    input  logic              wr_perm,
    output logic              rsp_valid,
    output logic [31:0]       lin_addr,
    output logic              fault,
    output logic [2:0]        fault_cause
);

    localparam logic [FIELD_W:0] DEPTH_V = (FIELD_W + 1)'(DEPTH);

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [2:0]        cause;
        logic [ADDR_W-1:0] lin;
    } rsp_t;

    rsp_t r_d, r_q;

    logic [PRIV_W-1:0]  sel_rpl;
    logic               sel_tbl;
    logic [FIELD_W-1:0] sel_idx;
    logic               in_range;
    desc_t              wr_desc;
    desc_t              tbl_rd [2];
    desc_t              cur_desc;
    cause_e             chk_cause;

    assign sel_rpl  = sel[1:0];
    assign sel_tbl  = sel[2];
    assign sel_idx  = sel[SEL_W-1:3];
    assign in_range = {1'b0, sel_idx} < DEPTH_V;

    always_comb begin
        wr_desc.base    = wr_base;
        wr_desc.limit   = wr_limit;
        wr_desc.dpl     = wr_dpl;
        wr_desc.present = wr_present;
        wr_desc.is_code = wr_code;
        wr_desc.perm    = wr_perm;
    end

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        seg_desc_table #(
            .DEPTH (DEPTH)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_local == 1'(t))),
            .wr_idx  (wr_idx),
            .wr_desc (wr_desc),
            .rd_idx  (sel_idx[IDX_W-1:0]),
            .rd_desc (tbl_rd[t])
        );
    end

    assign cur_desc = sel_tbl ? tbl_rd[1] : tbl_rd[0];

    seg_check u_chk (
        .desc     (cur_desc),
        .in_range (in_range),
        .cpl      (cpl),
        .rpl      (sel_rpl),
        .acc      (acc),
        .disp     (disp),
        .cause    (chk_cause)
    );

    always_comb begin
        r_d = '0;
        if (req_valid) begin
            r_d.vld = 1'b1;
            if (!seg_en) begin
                r_d.lin = disp;
            end else if (chk_cause != CAUSE_NONE) begin
                r_d.flt   = 1'b1;
                r_d.cause = chk_cause;
            end else begin
                r_d.lin = cur_desc.base + disp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid   = r_q.vld;
    assign lin_addr    = r_q.lin;
    assign fault       = r_q.flt;
    assign fault_cause = r_q.cause;

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_en) |=> (!fault && (lin_addr == $past(disp))));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_en && (sel[SEL_W-1:3] >= FIELD_W'(DEPTH)))
            |=> (fault && (fault_cause == 3'd1)));

    // R11
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ((lin_addr == '0) && (fault_cause != 3'd0) && rsp_valid));

    // R11
    clean_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_cause == 3'd0));

endmodule

// File: tb/seg_xlate_top_test.sv
module seg_xlate_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        seg_en = 1'b0;
    logic [13:0] sel = '0;
    logic [31:0] disp = '0;
    logic [1:0]  acc = '0;
    logic [1:0]  cpl = '0;
    logic        wr_en = 1'b0;
    logic        wr_local = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [31:0] wr_limit = '0;
    logic [1:0]  wr_dpl = '0;
    logic        wr_present = 1'b0;
    logic        wr_code = 1'b0;
    logic        wr_perm = 1'b0;
    logic        rsp_valid;
    logic [31:0] lin_addr;
    logic        fault;
    logic [2:0]  fault_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_xlate_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_en(seg_en),
        .sel(sel), .disp(disp), .acc(acc), .cpl(cpl),
        .wr_en(wr_en), .wr_local(wr_local), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_dpl(wr_dpl),
        .wr_present(wr_present), .wr_code(wr_code), .wr_perm(wr_perm),
        .rsp_valid(rsp_valid), .lin_addr(lin_addr), .fault(fault),
        .fault_cause(fault_cause)
    );

    // descriptor contents, computed from table and index
    function automatic logic [31:0] m_base(int t, int i);
        if (i == 15) return 32'hFFFF_FF00 - 32'(t) * 32'h10;
        return 32'h1000_0000 * 32'(t + 1) + 32'(i) * 32'h0001_0100 + 32'h35;
    endfunction
    function automatic logic [31:0] m_limit(int t, int i);
        return 32'h100 + 32'(i) * 32'd16 + 32'(t);
    endfunction
    function automatic logic [1:0] m_dpl(int t, int i);
        return 2'((i + t) % 4);
    endfunction
    function automatic logic m_present(int i);
        return (i % 5) != 4;
    endfunction
    function automatic logic m_code(int i);
        return 1'((i >> 1) & 1);
    endfunction
    function automatic logic m_perm(int t, int i);
        return 1'((i + t) & 1);
    endfunction

    function automatic logic [2:0] exp_cause(int t, int i, int a, int c, int r, logic [31:0] d);
        logic ok;
        if (i >= 16 || !m_present(i)) return 3'd1;
        if (c > int'(m_dpl(t, i)) || r > int'(m_dpl(t, i))) return 3'd2;
        case (a)
            0: ok = 1'b1;
            1: ok = !m_code(i) && m_perm(t, i);
            2: ok = m_code(i) && m_perm(t, i);
            default: ok = 1'b0;
        endcase
        if (!ok) return 3'd3;
        if (d > m_limit(t, i)) return 3'd4;
        return 3'd0;
    endfunction

    function automatic string cause_tag(logic [2:0] c);
        case (c)
            3'd1: return "R6/R10";
            3'd2: return "R7/R10";
            3'd3: return "R8/R10";
            3'd4: return "R9/R10";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(int t, int i);
        @(negedge clk);
        wr_en = 1'b1; wr_local = 1'(t); wr_idx = 4'(i);
        wr_base = m_base(t, i); wr_limit = m_limit(t, i); wr_dpl = m_dpl(t, i);
        wr_present = m_present(i); wr_code = m_code(i); wr_perm = m_perm(t, i);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one request, sample its registered response one falling edge later
    task automatic request(logic en, int t, int i, int a, int c, int r, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; seg_en = en;
        sel = {11'(i), 1'(t), 2'(r)};
        acc = 2'(a); cpl = 2'(c); disp = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(string tag, logic [2:0] ec, logic [31:0] el);
        check({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " cause"}, 32'(fault_cause), 32'(ec));
        check({tag, " R11 fault"}, 32'(fault), 32'(ec != 3'd0));
        check({tag, " addr"}, lin_addr, el);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]  ec;
        logic [31:0] dv;
        repeat (3) @(negedge clk);
        // R1 outputs held at zero in reset
        check("R1 valid", 32'(rsp_valid), 32'd0);
        check("R1 fault", 32'(fault), 32'd0);
        check("R1 cause", 32'(fault_cause), 32'd0);
        check("R1 addr", lin_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle valid", 32'(rsp_valid), 32'd0);

        // R1 cleared tables report not present
        request(1'b1, 0, 3, 0, 0, 0, 32'h10);
        expect_rsp("R1 global cleared", 3'd1, 32'd0);
        request(1'b1, 1, 7, 0, 0, 0, 32'h10);
        expect_rsp("R1 local cleared", 3'd1, 32'd0);

        // R12 write and lookup in the same cycle see the old entry
        @(negedge clk);
        wr_en = 1'b1; wr_local = 1'b0; wr_idx = 4'd0;
        wr_base = m_base(0, 0); wr_limit = m_limit(0, 0); wr_dpl = m_dpl(0, 0);
        wr_present = m_present(0); wr_code = m_code(0); wr_perm = m_perm(0, 0);
        req_valid = 1'b1; seg_en = 1'b1; sel = {11'd0, 1'b0, 2'd0};
        acc = 2'd0; cpl = 2'd0; disp = 32'h20;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R12 same cycle", 3'd1, 32'd0);
        request(1'b1, 0, 0, 0, 0, 0, 32'h20);
        expect_rsp("R12 after write", 3'd0, m_base(0, 0) + 32'h20);

        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 16; i++) begin
                load(t, i);
            end
        end

        // R2 response lasts exactly one cycle
        request(1'b1, 0, 0, 0, 0, 0, 32'h4);
        @(negedge clk);
        check("R2 single cycle", 32'(rsp_valid), 32'd0);

        // R3 bypass ignores selector, access and privilege
        for (int k = 0; k < 40; k++) begin
            dv = 32'h9E37_79B9 * 32'(k + 1);
            request(1'b0, k & 1, k % 18, k % 4, (k >> 1) % 4, (k >> 2) % 4, dv);
            expect_rsp("R3 bypass", 3'd0, dv);
        end

        // R4..R10 full sweep, R4 covers indices 16 and 17
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 18; i++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int c = 0; c < 4; c++) begin
                        for (int r = 0; r < 4; r++) begin
                            for (int dk = 0; dk < 3; dk++) begin
                                if (i >= 16) dv = 32'(dk) * 32'h40;
                                else if (dk == 0) dv = 32'd0;
                                else if (dk == 1) dv = m_limit(t, i);
                                else dv = m_limit(t, i) + 32'd1;
                                ec = exp_cause(t, i, a, c, r, dv);
                                request(1'b1, t, i, a, c, r, dv);
                                expect_rsp(i >= 16 ? "R4 index range" : cause_tag(ec), ec,
                                           (ec == 3'd0) ? m_base(t, i) + dv : 32'd0);
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule